// File: doc/BRIEF.md
# Glitch-Free Decoded Step Sequencer

This block steps a small binary counter through a fixed cycle of eight states (0 up to 7, then back to 0). It turns the count into eight active-low select lines, with exactly one line low in each state. Other logic uses these lines to enable one device per time slot.

A decoder driven straight from a counter can produce short false pulses when several count bits change on the same edge. For that reason the block gives two copies of the select lines. The raw copy comes from combinational logic and may glitch. The clean copy is the raw copy captured by a second register on the following edge. It comes straight from flip-flops and lags the raw copy by exactly one clock.

A synchronous clear returns the counter to state 0 and forces every clean line inactive. A count enable lets the sequence pause in place.

Top module: `step_select_seq`

## Requirements
- R1: On a clock edge with `clr_i` high, `count_o` becomes 0 and `reg_sel_n_o` becomes all ones, whatever `en_i` is. Clear has priority over enable.
- R2: On a clock edge with `clr_i` low and `en_i` high, `count_o` increases by 1. From 7 it wraps to 0.
- R3: On a clock edge with `clr_i` low and `en_i` low, `count_o` keeps its value, so `raw_sel_n_o` does not change.
- R4: Bit i of `raw_sel_n_o` is 0 exactly when `count_o` equals i, and every other bit is 1. This means exactly one raw line is low at any time.
- R5: On a clock edge with `clr_i` low, `reg_sel_n_o` takes the value that `raw_sel_n_o` had just before that edge. The registered lines therefore lag the raw lines by one clock, and the index of the low registered bit equals the previous cycle's count.
- R6: `reg_sel_n_o` never has more than one bit low. It is all ones only after a clear.
- R7: While `en_i` stays high, each registered line is low for exactly one clock in every eight consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| clr_i | input | 1 | Synchronous clear, active high |
| en_i | input | 1 | Count enable, active high |
| count_o | output | CNT_W (3) | Current counter state |
| raw_sel_n_o | output | 2**CNT_W (8) | Combinational active-low one-hot decode of `count_o` |
| reg_sel_n_o | output | 2**CNT_W (8) | Registered copy of `raw_sel_n_o`, one clock behind |

## Verification
A fault in the counter register shows on `count_o` and `raw_sel_n_o` at the edge where it happens. One edge later it also reaches `reg_sel_n_o`, as a wrong low index or as a line that stays low too long. A fault in the retiming register shows only on `reg_sel_n_o`: the low index no longer matches the count sampled one cycle before, or more than one line is low. The stimulus includes paused stretches, a wrap from 7 to 0, and a clear applied while enable is high. Each of these would reveal the mismatch within one or two clocks.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;

    // Control applied to the counter at each edge
    typedef struct packed {
        logic clr;
        logic en;
    } seq_ctrl_t;

endpackage

// File: rtl/seq_count.sv
`timescale 1ns/1ps
module seq_count #(
    parameter int unsigned CNT_W = 3
) (
    input  logic                  clk_i,
    input  seq_pkg::seq_ctrl_t    ctrl_i,
    output logic [CNT_W-1:0]      count_o
);
    localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (ctrl_i.clr) begin
            state_d.count = '0;
        end else if (ctrl_i.en) begin
            state_d.count = state_q.count + STEP;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign count_o = state_q.count;
endmodule

// File: rtl/seq_decode.sv
`timescale 1ns/1ps
module seq_decode #(
    parameter int unsigned CNT_W = 3,
    parameter int unsigned N_SEL = 1 << CNT_W
) (
    input  logic [CNT_W-1:0] count_i,
    output logic [N_SEL-1:0] sel_n_o
);
    for (genvar g = 0; g < N_SEL; g++) begin : g_line
        localparam logic [CNT_W-1:0] MATCH = CNT_W'(g);
        assign sel_n_o[g] = (count_i != MATCH);
    end
endmodule

// File: rtl/seq_retime.sv
`timescale 1ns/1ps
module seq_retime #(
    parameter int unsigned N_SEL = 8
) (
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic [N_SEL-1:0] sel_n_i,
    output logic [N_SEL-1:0] sel_n_o
);
    typedef struct packed {
        logic [N_SEL-1:0] sel_n;
    } rt_state_t;

    rt_state_t state_d, state_q;

    always_comb begin
        state_d.sel_n = clr_i ? '1 : sel_n_i;
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign sel_n_o = state_q.sel_n;
endmodule

// File: rtl/step_select_seq.sv
`timescale 1ns/1ps
module step_select_seq #(
    parameter int unsigned CNT_W = 3,
    localparam int unsigned N_SEL = 1 << CNT_W
) (
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] count_o,
    output logic [N_SEL-1:0] raw_sel_n_o,
    output logic [N_SEL-1:0] reg_sel_n_o
);
    seq_pkg::seq_ctrl_t ctrl;
    logic [CNT_W-1:0]   count;
    logic [N_SEL-1:0]   raw_sel_n;

    assign ctrl.clr = clr_i;
    assign ctrl.en  = en_i;

    seq_count #(.CNT_W(CNT_W)) u_count (
        .clk_i   (clk_i),
        .ctrl_i  (ctrl),
        .count_o (count)
    );

    seq_decode #(.CNT_W(CNT_W), .N_SEL(N_SEL)) u_decode (
        .count_i (count),
        .sel_n_o (raw_sel_n)
    );

    seq_retime #(.N_SEL(N_SEL)) u_retime (
        .clk_i   (clk_i),
        .clr_i   (clr_i),
        .sel_n_i (raw_sel_n),
        .sel_n_o (reg_sel_n_o)
    );

    assign count_o     = count;
    assign raw_sel_n_o = raw_sel_n;
endmodule

// File: rtl/step_select_seq_chk.sv
`timescale 1ns/1ps
module step_select_seq_chk #(
    parameter int unsigned CNT_W = 3,
    localparam int unsigned N_SEL = 1 << CNT_W
) (
    input logic             clk_i,
    input logic             clr_i,
    input logic             en_i,
    input logic [CNT_W-1:0] count_o,
    input logic [N_SEL-1:0] raw_sel_n_o,
    input logic [N_SEL-1:0] reg_sel_n_o
);
    localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

    // Becomes true once a clear has been seen; before that state is unknown
    logic armed_q = 1'b0;
    always_ff @(posedge clk_i) begin
        if (clr_i) armed_q <= 1'b1;
    end

    AST_CLEAR_STATE: assert property (@(posedge clk_i) disable iff (!armed_q)
        clr_i |=> (count_o == '0) && (reg_sel_n_o == '1)); // R1
    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!armed_q)
        (!clr_i && en_i) |=> count_o == $past(count_o) + STEP); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!armed_q)
        (!clr_i && !en_i) |=> $stable(count_o) && $stable(raw_sel_n_o)); // R3
    AST_RAW_ONE_LOW: assert property (@(posedge clk_i) disable iff (!armed_q)
        ($countones(~raw_sel_n_o) == 1) && !raw_sel_n_o[count_o]); // R4
    AST_REG_LAG: assert property (@(posedge clk_i) disable iff (!armed_q)
        !clr_i |=> reg_sel_n_o == $past(raw_sel_n_o)); // R5
    AST_REG_AT_MOST_ONE: assert property (@(posedge clk_i) disable iff (!armed_q)
        $onehot0(~reg_sel_n_o)); // R6
endmodule

bind step_select_seq step_select_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i       (clk_i),
    .clr_i       (clr_i),
    .en_i        (en_i),
    .count_o     (count_o),
    .raw_sel_n_o (raw_sel_n_o),
    .reg_sel_n_o (reg_sel_n_o)
);

// File: tb/step_select_seq_bench.sv
`timescale 1ns/1ps
module step_select_seq_bench;
    localparam int CNT_W = 3;
    localparam int N_SEL = 8;
    localparam int NV    = 20;

    logic             clk_i = 1'b0;
    logic             clr_i = 1'b1;
    logic             en_i  = 1'b0;
    logic [CNT_W-1:0] count_o;
    logic [N_SEL-1:0] raw_sel_n_o;
    logic [N_SEL-1:0] reg_sel_n_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk_i = ~clk_i; // 250 MHz

    step_select_seq #(.CNT_W(CNT_W)) u_step_select_seq (
        .clk_i(clk_i), .clr_i(clr_i), .en_i(en_i),
        .count_o(count_o), .raw_sel_n_o(raw_sel_n_o), .reg_sel_n_o(reg_sel_n_o)
    );

    // Each entry: {clr, en, expected count after the edge}
    localparam logic [4:0] VEC [NV] = '{
        {1'b1, 1'b0, 3'd0}, {1'b0, 1'b1, 3'd1}, {1'b0, 1'b1, 3'd2},
        {1'b0, 1'b0, 3'd2}, {1'b0, 1'b0, 3'd2}, {1'b0, 1'b1, 3'd3},
        {1'b0, 1'b1, 3'd4}, {1'b0, 1'b1, 3'd5}, {1'b0, 1'b1, 3'd6},
        {1'b0, 1'b1, 3'd7}, {1'b0, 1'b0, 3'd7}, {1'b0, 1'b1, 3'd0},
        {1'b0, 1'b1, 3'd1}, {1'b1, 1'b1, 3'd0}, {1'b0, 1'b1, 3'd1},
        {1'b0, 1'b0, 3'd1}, {1'b0, 1'b1, 3'd2}, {1'b0, 1'b1, 3'd3},
        {1'b1, 1'b0, 3'd0}, {1'b0, 1'b0, 3'd0}
    };

    function automatic logic [N_SEL-1:0] low_line(input int idx);
        return ~(N_SEL'(1) << idx);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [N_SEL-1:0] raw_before;
        logic [N_SEL-1:0] exp_reg;
        int               m_cnt;
        int               lows [N_SEL];

        m_cnt = 0;
        // Vector walk: drive on falling edge, sample 1 ns after rising edge
        for (int i = 0; i < NV; i++) begin
            logic v_clr, v_en;
            int   v_cnt;
            v_clr = VEC[i][4];
            v_en  = VEC[i][3];
            v_cnt = int'(VEC[i][2:0]);
            @(negedge clk_i);
            clr_i = v_clr;
            en_i  = v_en;
            raw_before = low_line(m_cnt);
            @(posedge clk_i);
            #1;
            exp_reg = v_clr ? '1 : raw_before;
            m_cnt   = v_cnt;
            if (v_clr)      check("R1", "count after clear", 32'(count_o), 32'(v_cnt));
            else if (v_en)  check("R2", "count step",        32'(count_o), 32'(v_cnt));
            else            check("R3", "count hold",        32'(count_o), 32'(v_cnt));
            check("R4", "raw decode", 32'(raw_sel_n_o), 32'(low_line(v_cnt)));
            if (v_clr)      check("R1", "registered cleared", 32'(reg_sel_n_o), 32'(exp_reg));
            else begin
                check("R5", "registered lag", 32'(reg_sel_n_o), 32'(exp_reg));
                check("R6", "registered one low", 32'($countones(~reg_sel_n_o)), 32'd1);
            end
        end

        // Directed: clear at state 7 with enable high, then resume
        @(negedge clk_i); clr_i = 1'b0; en_i = 1'b1;
        for (int k = 0; k < 7; k++) @(negedge clk_i);
        check("R2", "reached seven", 32'(count_o), 32'd7);
        clr_i = 1'b1;
        @(posedge clk_i); #1;
        check("R1", "clear beats enable count", 32'(count_o), 32'd0);
        check("R1", "clear beats enable reg", 32'(reg_sel_n_o), 32'hFF);
        @(negedge clk_i); clr_i = 1'b0;
        @(posedge clk_i); #1;
        check("R5", "reg shows state zero", 32'(reg_sel_n_o), 32'(low_line(0)));
        check("R2", "count after release", 32'(count_o), 32'd1);

        // Duty check: 64 enabled clocks, each registered line low 8 times
        for (int j = 0; j < N_SEL; j++) lows[j] = 0;
        for (int c = 0; c < 64; c++) begin
            @(posedge clk_i); #1;
            for (int j = 0; j < N_SEL; j++) if (!reg_sel_n_o[j]) lows[j]++;
        end
        for (int j = 0; j < N_SEL; j++)
            check("R7", $sformatf("low count line %0d", j), 32'(lows[j]), 32'd8);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule